// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words, A and B, and reports one of three relations: greater, less or equal. It is built from 4-bit stages. Each stage looks at the bits from the most significant one downward. The first bit position where the two nibbles differ settles the stage's result. A stage that finds its nibbles identical passes on a result that it derives from three cascade inputs. Those inputs come from the stage below, or from the block's own cascade pins for the lowest stage. Any monotonic code, such as binary or BCD, works, because each nibble is weighed only as an unsigned number.

The top module wires `STAGES` of these stages in series. Stage 0 holds the least significant nibble, and each stage's three flags drive the cascade inputs of the stage above it with no gating in between. For a plain compare, tie the equal cascade pin high and the other two cascade pins low. The cascade pins also have defined results for combinations that are not one-hot. An all-equal word applies the merge rule below once in every stage. As a result, codes that are not one-hot alternate along a chain.

Top module: `magcmp_chain`

## Requirements
- R1: When A is greater than B as an unsigned number, gt_o is 1 and lt_o and eq_o are 0, whatever the cascade pins carry. Within a stage, the highest bit position that differs decides the result.
- R2: When A is less than B, lt_o is 1 and gt_o and eq_o are 0, whatever the cascade pins carry.
- R3: Whenever A differs from B, exactly one of the three outputs is high.
- R4: With A equal to B and exactly one cascade pin high, the outputs of a single stage copy the cascade pins: casc_gt_i gives gt_o, casc_lt_i gives lt_o and casc_eq_i gives eq_o.
- R5: With A equal to B and casc_eq_i high, the outputs are eq_o = 1, gt_o = 0 and lt_o = 0, whatever casc_gt_i and casc_lt_i carry.
- R6: In a single stage with A equal to B, if casc_gt_i and casc_lt_i are both high and casc_eq_i is low, all three outputs are 0.
- R7: In a single stage with A equal to B, if all three cascade pins are low, gt_o and lt_o are both 1 and eq_o is 0.
- R8: Each stage whose nibbles match maps cascade flags (g, l, e) to (!e & !l, !e & !g, e). For equal words the result is this map applied `STAGES` times to the cascade pins. For example, with 2 stages, all-low cascade pins give all-low outputs.
- R9: In a chain, a difference in a more significant nibble outranks any difference in a less significant nibble.
- R10: eq_o is high only when A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | 4*STAGES | Word A, unsigned; bit 0 is the least significant |
| b_word | input | 4*STAGES | Word B, unsigned |
| casc_gt_i | input | 1 | Greater flag from a less significant block |
| casc_lt_i | input | 1 | Less flag from a less significant block |
| casc_eq_i | input | 1 | Equal flag from a less significant block |
| gt_o | output | 1 | A is greater than B |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B (as resolved through the cascade) |

## Verification
The block holds no state. A wrong internal decision therefore reaches the ports in the same evaluation as the input change, and it stays there as long as that input stays. A fault in the bit scan shows up as a wrong flag or as two flags set on unequal words. A fault in the cascade merge shows up only on equal words, and there it depends on the cascade code. A single stage is swept through all nibble pairs and all eight cascade codes. The chained form is exercised with equal words and with conflicting nibble differences, so that both the alternation and the priority order of R8 and R9 are visible.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
    localparam int NIB_W = 4;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } rel_t;
endpackage

// File: rtl/mag_scan.sv
module mag_scan
    import magcmp_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         gt_o,
    output logic         lt_o,
    output logic         tie_o
);
    logic same_above;

    // Walk from the top bit down; the first mismatch wins.
    always_comb begin
        same_above = 1'b1;
        gt_o       = 1'b0;
        lt_o       = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (same_above) begin
                if (a_i[i] & ~b_i[i]) gt_o = 1'b1;
                if (~a_i[i] & b_i[i]) lt_o = 1'b1;
            end
            same_above = same_above & (a_i[i] == b_i[i]);
        end
        tie_o = same_above;
    end
endmodule

// File: rtl/casc_merge.sv
module casc_merge
    import magcmp_pkg::*;
(
    input  logic local_gt_i,
    input  logic local_lt_i,
    input  logic local_tie_i,
    input  rel_t below_i,
    output rel_t rel_o
);
    always_comb begin
        if (!local_tie_i) begin
            rel_o.gt = local_gt_i;
            rel_o.lt = local_lt_i;
            rel_o.eq = 1'b0;
        end else begin
            rel_o.gt = ~below_i.eq & ~below_i.lt;
            rel_o.lt = ~below_i.eq & ~below_i.gt;
            rel_o.eq = below_i.eq;
        end
    end
endmodule

// File: rtl/magcmp_stage.sv
module magcmp_stage
    import magcmp_pkg::*;
(
    input  logic [NIB_W-1:0] a_nib_i,
    input  logic [NIB_W-1:0] b_nib_i,
    input  rel_t             below_i,
    output rel_t             rel_o
);
    logic s_gt, s_lt, s_tie;

    mag_scan #(.W(NIB_W)) u_scan (
        .a_i   (a_nib_i),
        .b_i   (b_nib_i),
        .gt_o  (s_gt),
        .lt_o  (s_lt),
        .tie_o (s_tie)
    );

    casc_merge u_merge (
        .local_gt_i  (s_gt),
        .local_lt_i  (s_lt),
        .local_tie_i (s_tie),
        .below_i     (below_i),
        .rel_o       (rel_o)
    );
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic [STAGES*4-1:0] a_word,
    input  logic [STAGES*4-1:0] b_word,
    input  logic                casc_gt_i,
    input  logic                casc_lt_i,
    input  logic                casc_eq_i,
    output logic                gt_o,
    output logic                lt_o,
    output logic                eq_o
);
    localparam int WORD_W = STAGES * NIB_W;

    for (genvar k = 0; k < STAGES; k++) begin : g_st
        rel_t cin;
        rel_t cout;
        if (k == 0) begin : g_first
            assign cin = '{gt: casc_gt_i, lt: casc_lt_i, eq: casc_eq_i};
        end else begin : g_next
            assign cin = g_st[k-1].cout;
        end
        magcmp_stage u_stage (
            .a_nib_i (a_word[k*NIB_W +: NIB_W]),
            .b_nib_i (b_word[k*NIB_W +: NIB_W]),
            .below_i (cin),
            .rel_o   (cout)
        );
    end

    assign gt_o = g_st[STAGES-1].cout.gt;
    assign lt_o = g_st[STAGES-1].cout.lt;
    assign eq_o = g_st[STAGES-1].cout.eq;

    initial begin
        if (WORD_W != $bits(a_word)) $error("word width mismatch");
    end
endmodule

// File: rtl/magcmp_chain_chk.sv
module magcmp_chain_chk #(
    parameter int STAGES = 2
) (
    input logic [STAGES*4-1:0] a_word,
    input logic [STAGES*4-1:0] b_word,
    input logic                casc_gt_i,
    input logic                casc_lt_i,
    input logic                casc_eq_i,
    input logic                gt_o,
    input logic                lt_o,
    input logic                eq_o
);
    always_comb begin
        if (a_word > b_word) begin
            a_r1_greater_only: assert (gt_o && !lt_o && !eq_o)
                else $error("R1 greater flags wrong");
        end
        if (a_word < b_word) begin
            a_r2_less_only: assert (lt_o && !gt_o && !eq_o)
                else $error("R2 less flags wrong");
        end
        if (a_word != b_word) begin
            a_r3_single_flag: assert ($countones({gt_o, lt_o, eq_o}) == 1)
                else $error("R3 not one flag");
        end
        if (a_word == b_word && casc_eq_i) begin
            a_r5_equal_wins: assert (eq_o && !gt_o && !lt_o)
                else $error("R5 equal cascade not honoured");
        end
        if (eq_o) begin
            a_r10_eq_needs_match: assert (a_word == b_word)
                else $error("R10 eq on unequal words");
        end
    end
endmodule

bind magcmp_chain magcmp_chain_chk #(.STAGES(STAGES)) u_chk (
    .a_word    (a_word),
    .b_word    (b_word),
    .casc_gt_i (casc_gt_i),
    .casc_lt_i (casc_lt_i),
    .casc_eq_i (casc_eq_i),
    .gt_o      (gt_o),
    .lt_o      (lt_o),
    .eq_o      (eq_o)
);

// File: tb/magcmp_chain_tb_top.sv
module magcmp_chain_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIDE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // single-stage instance
    logic [3:0] sa, sb;
    logic [2:0] sc;            // {gt_in, lt_in, eq_in}
    logic s_gt, s_lt, s_eq;
    magcmp_chain #(.STAGES(1)) dut_i (
        .a_word(sa), .b_word(sb),
        .casc_gt_i(sc[2]), .casc_lt_i(sc[1]), .casc_eq_i(sc[0]),
        .gt_o(s_gt), .lt_o(s_lt), .eq_o(s_eq)
    );

    // chained instance
    logic [WIDE*4-1:0] wa, wb;
    logic [2:0] wc;
    logic w_gt, w_lt, w_eq;
    magcmp_chain #(.STAGES(WIDE)) dut_w (
        .a_word(wa), .b_word(wb),
        .casc_gt_i(wc[2]), .casc_lt_i(wc[1]), .casc_eq_i(wc[0]),
        .gt_o(w_gt), .lt_o(w_lt), .eq_o(w_eq)
    );

    // Reference: unsigned compare, else merge rule once per stage.
    function automatic logic [2:0] model(longint unsigned a, longint unsigned b,
                                         logic [2:0] c, int n);
        logic [2:0] r;
        if (a > b) return 3'b100;
        if (a < b) return 3'b010;
        r = c;
        for (int k = 0; k < n; k++)
            r = {~r[0] & ~r[1], ~r[0] & ~r[2], r[0]};
        return r;
    endfunction

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_single();
        string tag;
        logic [2:0] exp;
        exp = model(sa, sb, sc, 1);
        if (sa > sb)            tag = "R1";
        else if (sa < sb)       tag = "R2";
        else if (sc[0])         tag = "R5";
        else if (sc == 3'b110)  tag = "R6";
        else if (sc == 3'b000)  tag = "R7";
        else                    tag = "R4";
        check(tag, {s_gt, s_lt, s_eq}, exp);
        if (sa != sb)
            check("R3", 3'($countones({s_gt, s_lt, s_eq})), 3'd1);
        check("R10", {2'b00, s_eq}, {2'b00, (sa == sb) && sc[0]});
    endtask

    task automatic check_wide();
        string tag;
        tag = (wa == wb) ? "R8" : "R9";
        check(tag, {w_gt, w_lt, w_eq}, model(wa, wb, wc, WIDE));
    endtask

    task automatic apply_wide(logic [WIDE*4-1:0] a, logic [WIDE*4-1:0] b, logic [2:0] c);
        @(posedge clk); #1;
        wa = a; wb = b; wc = c;
        @(negedge clk);
        check_wide();
    endtask

    initial begin
        sa = '0; sb = '0; sc = 3'b001;
        wa = '0; wb = '0; wc = 3'b001;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: idle state after reset, equal words with equal cascade
        check("R5", {s_gt, s_lt, s_eq}, 3'b001);
        check("R5", {w_gt, w_lt, w_eq}, 3'b001);

        // Exhaustive single-stage sweep
        for (int v = 0; v < 2048; v++) begin
            @(posedge clk); #1;
            {sa, sb, sc} = v[10:0];
            @(negedge clk);
            check_single();
        end

        // R8: equal wide words, every cascade code (alternation over 3 stages)
        for (int c = 0; c < 8; c++)
            apply_wide(12'h5A3, 12'h5A3, c[2:0]);
        // R9: top nibble outranks lower ones
        apply_wide(12'h200, 12'h1FF, 3'b010);
        apply_wide(12'h0FF, 12'h100, 3'b100);
        apply_wide(12'h34F, 12'h350, 3'b001);
        apply_wide(12'h351, 12'h34F, 3'b000);

        // Mixed pseudorandom wide vectors
        for (int i = 0; i < 1500; i++) begin
            logic [WIDE*4-1:0] ra, rb;
            ra = 12'($urandom);
            rb = (i % 4 == 0) ? ra : ((i % 4 == 1) ? (ra ^ (12'h1 << (i % 12))) : 12'($urandom));
            apply_wide(ra, rb, 3'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule